// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits behind a translation cache. Several translation requests that hit the same virtual page are merged into one entry of an outstanding-page table. When the single translation for that page comes back, this block returns one response to each of the original requests. It finds the table entry whose page key matches the response. It then walks the entry's members, one per cycle, in the order they were recorded. For each member it forms the full physical address from the translated page base and that member's own offset within the page. It copies the uncacheable and hit-level attributes onto every member response and steers each one to the requester port that member arrived on.

The page size arrives with the response as a log2 value, so 4 KiB and 2 MiB pages go through the same path. The response stays on its input with ready low until the last member has been handed off. In that final cycle the block raises a cleanup strobe. The matching table entry stays visible to the issue-side query port for the rest of that cycle and is gone from the next cycle on. A response whose key matches no valid entry is flagged as an error and consumed without producing any member output. The table is filled through a slot-allocation port and a member-write port, both driven by the merge logic.

Top module: `tr_resp_distrib`

## Requirements
- R1: After reset, no table entry is valid (qry_hit_o low for any key), out_valid_o is low and rsp_ready_o is low while rsp_valid_i is low.
- R2: Each member's out_paddr_o equals rsp_paddr_i with bits below rsp_page_log2_i cleared, ORed with that member's virtual address masked to those low bits.
- R3: out_uncache_o equals rsp_uncache_i on every member response.
- R4: out_hit_lvl_o equals rsp_hit_lvl_i on every member response.
- R5: out_port_o carries the requester port written for that member.
- R6: out_pop_o is high for a member written with prefetch 0 and low for a member written with prefetch 1.
- R7: Members leave in index order 0 to count-1, one per out_valid_o/out_ready_i handshake. out_last_o is high only on index count-1. While out_ready_i is low, out_valid_o and the member fields hold steady.
- R8: On a matched response, rsp_ready_o is high only in the cycle of the last member's handshake.
- R9: clr_o pulses in the last member's handshake cycle. In that cycle the entry is still reported by qry_hit_o, and from the next cycle on it is not. Other entries are unaffected.
- R10: A valid response whose key matches no valid entry raises err_o and rsp_ready_o in the same cycle, keeps out_valid_o low and leaves the table unchanged.
- R11: Both 12 and 21 as rsp_page_log2_i produce correct addresses, so offsets above bit 11 pass through on large pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_we_i | input | 1 | Allocate a table slot |
| alloc_slot_i | input | SLOT_W | Slot to allocate |
| alloc_vkey_i | input | KEY_W | Virtual page key of the slot |
| alloc_cnt_i | input | CNT_W | Number of members in the slot (1 to MEMB) |
| memb_we_i | input | 1 | Write one member record |
| memb_slot_i | input | SLOT_W | Slot of the member |
| memb_idx_i | input | IDX_W | Member position within the slot |
| memb_vaddr_i | input | VA_W | Member virtual address |
| memb_port_i | input | PORT_W | Requester port of the member |
| memb_pf_i | input | 1 | Member is a prefetch |
| rsp_valid_i | input | 1 | Translation response valid |
| rsp_ready_o | output | 1 | Response consumed |
| rsp_vkey_i | input | KEY_W | Virtual page key of the response |
| rsp_paddr_i | input | PA_W | Translated physical address |
| rsp_page_log2_i | input | LOG2_W | log2 of the page size |
| rsp_uncache_i | input | 1 | Uncacheable attribute |
| rsp_hit_lvl_i | input | LVL_W | Level where the translation hit |
| out_valid_o | output | 1 | Member response valid |
| out_ready_i | input | 1 | Member response accepted |
| out_paddr_o | output | PA_W | Member physical address |
| out_port_o | output | PORT_W | Destination requester port |
| out_uncache_o | output | 1 | Uncacheable attribute |
| out_hit_lvl_o | output | LVL_W | Hit-level tag |
| out_pop_o | output | 1 | Pop this level's request count |
| out_last_o | output | 1 | Final member of the entry |
| clr_o | output | 1 | Outstanding entry retired this cycle |
| clr_vkey_o | output | KEY_W | Key of the retired entry |
| err_o | output | 1 | Response matched no entry |
| qry_vkey_i | input | KEY_W | Issue-side outstanding query key |
| qry_hit_o | output | 1 | Query key is outstanding |

## Verification
The bench uses the default parameters: 32-bit virtual and physical addresses, a 4 KiB minimum page, four slots of four members each, and four requester ports. With these values a single-member entry can be retired from several slots' worth of patterns at both page sizes. A three-member entry reaches a late index with a stall on its first member. A second resident entry shows that retiring one page leaves its neighbour in place. The 5-bit log2 field carries 21, so the bench can check offsets that extend well past the 4 KiB boundary.

// File: rtl/tr_dist_pkg.sv
package tr_dist_pkg;
  localparam int unsigned TD_VA_W        = 32;
  localparam int unsigned TD_PA_W        = 32;
  localparam int unsigned TD_MIN_PG_LOG2 = 12;
  localparam int unsigned TD_SLOTS       = 4;
  localparam int unsigned TD_MEMB        = 4;
  localparam int unsigned TD_PORTS       = 4;
  localparam int unsigned TD_LVL_W       = 2;
  localparam int unsigned TD_LOG2_W      = 5;

  function automatic int unsigned td_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tr_dist_table.sv
module tr_dist_table #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned KEY_W  = 20,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned MEMB   = 4,
  parameter int unsigned PORT_W = 2,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_we_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [KEY_W-1:0]  alloc_vkey_i,
  input  logic [CNT_W-1:0]  alloc_cnt_i,
  input  logic              memb_we_i,
  input  logic [SLOT_W-1:0] memb_slot_i,
  input  logic [IDX_W-1:0]  memb_idx_i,
  input  logic [VA_W-1:0]   memb_vaddr_i,
  input  logic [PORT_W-1:0] memb_port_i,
  input  logic              memb_pf_i,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic [KEY_W-1:0]  look_vkey_i,
  output logic              look_hit_o,
  output logic [SLOT_W-1:0] look_slot_o,
  output logic [CNT_W-1:0]  look_cnt_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [VA_W-1:0]   rd_vaddr_o,
  output logic [PORT_W-1:0] rd_port_o,
  output logic              rd_pf_o,
  input  logic [KEY_W-1:0]  qry_vkey_i,
  output logic              qry_hit_o
);
  logic [SLOTS-1:0]  vld_q;
  logic [KEY_W-1:0]  key_q   [SLOTS];
  logic [CNT_W-1:0]  cnt_q   [SLOTS];
  logic [VA_W-1:0]   vaddr_q [SLOTS][MEMB];
  logic [PORT_W-1:0] port_q  [SLOTS][MEMB];
  logic              pf_q    [SLOTS][MEMB];
  logic [SLOTS-1:0]  look_match, qry_match;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[s] <= 1'b0;
      else if (alloc_we_i && alloc_slot_i == SLOT_W'(s)) vld_q[s] <= 1'b1;
      else if (clr_i && clr_slot_i == SLOT_W'(s)) vld_q[s] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (alloc_we_i && alloc_slot_i == SLOT_W'(s)) begin
        key_q[s] <= alloc_vkey_i;
        cnt_q[s] <= alloc_cnt_i;
      end
    end

    for (genvar m = 0; m < MEMB; m++) begin : g_memb
      always_ff @(posedge clk_i) begin
        if (memb_we_i && memb_slot_i == SLOT_W'(s) && memb_idx_i == IDX_W'(m)) begin
          vaddr_q[s][m] <= memb_vaddr_i;
          port_q[s][m]  <= memb_port_i;
          pf_q[s][m]    <= memb_pf_i;
        end
      end
    end

    assign look_match[s] = vld_q[s] && key_q[s] == look_vkey_i;
    assign qry_match[s]  = vld_q[s] && key_q[s] == qry_vkey_i;
  end

  // lowest matching slot wins
  always_comb begin
    look_hit_o  = 1'b0;
    look_slot_o = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (look_match[s]) begin
        look_hit_o  = 1'b1;
        look_slot_o = SLOT_W'(s);
      end
    end
  end

  assign look_cnt_o = cnt_q[look_slot_o];
  assign rd_vaddr_o = vaddr_q[look_slot_o][rd_idx_i];
  assign rd_port_o  = port_q[look_slot_o][rd_idx_i];
  assign rd_pf_o    = pf_q[look_slot_o][rd_idx_i];
  assign qry_hit_o  = |qry_match;

  // R9
  clr_gone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(alloc_we_i && alloc_slot_i == clr_slot_i) |=> !vld_q[$past(clr_slot_i)]);
endmodule

// File: rtl/tr_dist_seq.sv
module tr_dist_seq #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsp_valid_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             out_ready_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             out_valid_o,
  output logic             last_o,
  output logic             rsp_ready_o,
  output logic             clr_o,
  output logic             err_o
);
  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign idx_o       = idx_q;
  assign out_valid_o = rsp_valid_i && hit_i;
  assign last_o      = CNT_W'(idx_q) == cnt_i - CNT_W'(1);
  assign fire        = out_valid_o && out_ready_i;
  assign clr_o       = fire && last_o;
  assign err_o       = rsp_valid_i && !hit_i;
  assign rsp_ready_o = err_o || clr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (fire) idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
  end

  // R7
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !last_o |=> idx_q == IDX_W'($past(idx_q) + IDX_W'(1)));
  // R8
  idx_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> idx_q == '0);
endmodule

// File: rtl/tr_dist_compose.sv
module tr_dist_compose #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned LOG2_W = 5
) (
  input  logic [PA_W-1:0]   page_pa_i,
  input  logic [LOG2_W-1:0] page_log2_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic [PA_W-1:0]   paddr_o
);
  logic [PA_W-1:0] mask, vext;

  assign mask    = (PA_W'(1) << page_log2_i) - PA_W'(1);
  assign vext    = PA_W'(vaddr_i);
  assign paddr_o = (page_pa_i & ~mask) | (vext & mask);
endmodule

// File: rtl/tr_resp_distrib.sv
module tr_resp_distrib
  import tr_dist_pkg::*;
#(
  parameter int unsigned VA_W        = TD_VA_W,
  parameter int unsigned PA_W        = TD_PA_W,
  parameter int unsigned MIN_PG_LOG2 = TD_MIN_PG_LOG2,
  parameter int unsigned SLOTS       = TD_SLOTS,
  parameter int unsigned MEMB        = TD_MEMB,
  parameter int unsigned PORTS       = TD_PORTS,
  parameter int unsigned LVL_W       = TD_LVL_W,
  parameter int unsigned LOG2_W      = TD_LOG2_W,
  localparam int unsigned KEY_W      = VA_W - MIN_PG_LOG2,
  localparam int unsigned SLOT_W     = td_bits(SLOTS),
  localparam int unsigned IDX_W      = td_bits(MEMB),
  localparam int unsigned CNT_W      = $clog2(MEMB + 1),
  localparam int unsigned PORT_W     = td_bits(PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_we_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [KEY_W-1:0]  alloc_vkey_i,
  input  logic [CNT_W-1:0]  alloc_cnt_i,
  input  logic              memb_we_i,
  input  logic [SLOT_W-1:0] memb_slot_i,
  input  logic [IDX_W-1:0]  memb_idx_i,
  input  logic [VA_W-1:0]   memb_vaddr_i,
  input  logic [PORT_W-1:0] memb_port_i,
  input  logic              memb_pf_i,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [KEY_W-1:0]  rsp_vkey_i,
  input  logic [PA_W-1:0]   rsp_paddr_i,
  input  logic [LOG2_W-1:0] rsp_page_log2_i,
  input  logic              rsp_uncache_i,
  input  logic [LVL_W-1:0]  rsp_hit_lvl_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [PA_W-1:0]   out_paddr_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_uncache_o,
  output logic [LVL_W-1:0]  out_hit_lvl_o,
  output logic              out_pop_o,
  output logic              out_last_o,
  output logic              clr_o,
  output logic [KEY_W-1:0]  clr_vkey_o,
  output logic              err_o,
  input  logic [KEY_W-1:0]  qry_vkey_i,
  output logic              qry_hit_o
);
  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [VA_W-1:0]   m_vaddr;
  logic              m_pf;

  tr_dist_table #(
    .VA_W(VA_W), .KEY_W(KEY_W), .SLOTS(SLOTS), .MEMB(MEMB),
    .PORT_W(PORT_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_table (
    .clk_i, .rst_ni,
    .alloc_we_i, .alloc_slot_i, .alloc_vkey_i, .alloc_cnt_i,
    .memb_we_i, .memb_slot_i, .memb_idx_i, .memb_vaddr_i, .memb_port_i, .memb_pf_i,
    .clr_i       (clr_o),
    .clr_slot_i  (slot),
    .look_vkey_i (rsp_vkey_i),
    .look_hit_o  (hit),
    .look_slot_o (slot),
    .look_cnt_o  (cnt),
    .rd_idx_i    (idx),
    .rd_vaddr_o  (m_vaddr),
    .rd_port_o   (out_port_o),
    .rd_pf_o     (m_pf),
    .qry_vkey_i, .qry_hit_o
  );

  tr_dist_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .rsp_valid_i,
    .hit_i       (hit),
    .cnt_i       (cnt),
    .out_ready_i,
    .idx_o       (idx),
    .out_valid_o,
    .last_o      (out_last_o),
    .rsp_ready_o,
    .clr_o,
    .err_o
  );

  tr_dist_compose #(.VA_W(VA_W), .PA_W(PA_W), .LOG2_W(LOG2_W)) u_compose (
    .page_pa_i   (rsp_paddr_i),
    .page_log2_i (rsp_page_log2_i),
    .vaddr_i     (m_vaddr),
    .paddr_o     (out_paddr_o)
  );

  assign out_uncache_o = rsp_uncache_i;
  assign out_hit_lvl_o = rsp_hit_lvl_i;
  assign out_pop_o     = !m_pf;
  assign clr_vkey_o    = rsp_vkey_i;

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && $stable(rsp_vkey_i) && rsp_valid_i
      |=> out_valid_o && $stable(out_paddr_o) && $stable(out_port_o) && $stable(out_pop_o));
  // R10
  miss_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_ready_o && !out_valid_o && !clr_o);
  // R2
  page_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_paddr_o ^ rsp_paddr_i) >> rsp_page_log2_i) == '0);
  // R9
  clr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o && qry_vkey_i == rsp_vkey_i |-> qry_hit_o);
endmodule

// File: tb/tb_tr_resp_distrib.sv
module tb_tr_resp_distrib;
  typedef struct packed {
    logic [31:0] va;
    logic [31:0] pa;
    logic [4:0]  lg;
    logic [1:0]  port;
    logic        pf;
    logic        unc;
    logic [1:0]  lvl;
  } vec_t;

  // R2 R3 R4 R5 R6 R11 single-member vectors
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 32'hABCD_E999, 5'd12, 2'd0, 1'b0, 1'b0, 2'd1},
    '{32'h0040_1ABC, 32'h3FE0_0123, 5'd21, 2'd3, 1'b1, 1'b1, 2'd2},
    '{32'hFFFF_FFFF, 32'h0000_1000, 5'd12, 2'd1, 1'b0, 1'b1, 2'd0},
    '{32'h00BF_F001, 32'h8020_0000, 5'd21, 2'd2, 1'b0, 1'b0, 2'd3},
    '{32'h7000_0000, 32'hFFFF_FFFF, 5'd12, 2'd2, 1'b1, 1'b0, 2'd1},
    '{32'hDEAD_BEEF, 32'h1111_1111, 5'd21, 2'd1, 1'b0, 1'b1, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_we = 1'b0;
  logic [1:0]  alloc_slot = '0;
  logic [19:0] alloc_vkey = '0;
  logic [2:0]  alloc_cnt = '0;
  logic        memb_we = 1'b0;
  logic [1:0]  memb_slot = '0;
  logic [1:0]  memb_idx = '0;
  logic [31:0] memb_vaddr = '0;
  logic [1:0]  memb_port = '0;
  logic        memb_pf = 1'b0;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [19:0] rsp_vkey = '0;
  logic [31:0] rsp_paddr = '0;
  logic [4:0]  rsp_lg = 5'd12;
  logic        rsp_unc = 1'b0;
  logic [1:0]  rsp_lvl = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_paddr;
  logic [1:0]  out_port;
  logic        out_unc;
  logic [1:0]  out_lvl;
  logic        out_pop, out_last, clr, err, qry_hit;
  logic [19:0] clr_vkey;
  logic [19:0] qry_vkey = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tr_resp_distrib dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_we_i(alloc_we), .alloc_slot_i(alloc_slot), .alloc_vkey_i(alloc_vkey), .alloc_cnt_i(alloc_cnt),
    .memb_we_i(memb_we), .memb_slot_i(memb_slot), .memb_idx_i(memb_idx), .memb_vaddr_i(memb_vaddr),
    .memb_port_i(memb_port), .memb_pf_i(memb_pf),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_vkey_i(rsp_vkey), .rsp_paddr_i(rsp_paddr),
    .rsp_page_log2_i(rsp_lg), .rsp_uncache_i(rsp_unc), .rsp_hit_lvl_i(rsp_lvl),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_paddr_o(out_paddr), .out_port_o(out_port),
    .out_uncache_o(out_unc), .out_hit_lvl_o(out_lvl), .out_pop_o(out_pop), .out_last_o(out_last),
    .clr_o(clr), .clr_vkey_o(clr_vkey), .err_o(err), .qry_vkey_i(qry_vkey), .qry_hit_o(qry_hit)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] exp_pa(input logic [31:0] va, input logic [31:0] pa, input int lg);
    logic [63:0] sz;
    sz = 64'd1 << lg;
    return 32'((({32'd0, pa} / sz) * sz) + ({32'd0, va} % sz));
  endfunction

  task automatic alloc(input logic [1:0] s, input logic [19:0] k, input logic [2:0] c);
    @(negedge clk);
    alloc_we = 1'b1; alloc_slot = s; alloc_vkey = k; alloc_cnt = c;
    @(negedge clk);
    alloc_we = 1'b0;
  endtask

  task automatic memb(input logic [1:0] s, input logic [1:0] i, input logic [31:0] va,
                      input logic [1:0] p, input logic pf);
    @(negedge clk);
    memb_we = 1'b1; memb_slot = s; memb_idx = i; memb_vaddr = va; memb_port = p; memb_pf = pf;
    @(negedge clk);
    memb_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] m_va [3];
    logic [1:0]  m_pt [3];
    logic        m_pf [3];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(rsp_ready == 1'b0, "R1 rsp_ready", 32'(rsp_ready), 0);
    chk(qry_hit == 1'b0, "R1 qry_hit", 32'(qry_hit), 0);

    for (int v = 0; v < NV; v++) begin
      alloc(2'd0, VECS[v].va[31:12], 3'd1);
      memb(2'd0, 2'd0, VECS[v].va, VECS[v].port, VECS[v].pf);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_vkey = VECS[v].va[31:12]; rsp_paddr = VECS[v].pa;
      rsp_lg = VECS[v].lg; rsp_unc = VECS[v].unc; rsp_lvl = VECS[v].lvl;
      out_ready = 1'b1; qry_vkey = VECS[v].va[31:12];
      #2;
      chk(out_valid == 1'b1, "R7 single valid", 32'(out_valid), 1);
      chk(out_paddr == exp_pa(VECS[v].va, VECS[v].pa, int'(VECS[v].lg)), "R2/R11 paddr",
          out_paddr, exp_pa(VECS[v].va, VECS[v].pa, int'(VECS[v].lg)));
      chk(out_unc == VECS[v].unc, "R3 uncache", 32'(out_unc), 32'(VECS[v].unc));
      chk(out_lvl == VECS[v].lvl, "R4 hit level", 32'(out_lvl), 32'(VECS[v].lvl));
      chk(out_port == VECS[v].port, "R5 port", 32'(out_port), 32'(VECS[v].port));
      chk(out_pop == !VECS[v].pf, "R6 pop", 32'(out_pop), 32'(!VECS[v].pf));
      chk(out_last && rsp_ready && clr, "R8 single-member retire", {29'd0, out_last, rsp_ready, clr}, 7);
      chk(qry_hit == 1'b1, "R9 live in retire cycle", 32'(qry_hit), 1);
      @(negedge clk);
      rsp_valid = 1'b0;
      #2;
      chk(qry_hit == 1'b0, "R9 gone after retire", 32'(qry_hit), 0);
    end

    // R7 R8 R9 three-member entry, neighbour in slot 1
    m_va = '{32'h1234_5010, 32'h1234_5FF0, 32'h1234_5804};
    m_pt = '{2'd3, 2'd1, 2'd2};
    m_pf = '{1'b0, 1'b1, 1'b0};
    alloc(2'd1, 20'h0ABCD, 3'd1);
    memb(2'd1, 2'd0, 32'h0ABC_D000, 2'd0, 1'b0);
    alloc(2'd2, 20'h12345, 3'd3);
    for (int i = 0; i < 3; i++) memb(2'd2, 2'(i), m_va[i], m_pt[i], m_pf[i]);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_vkey = 20'h12345; rsp_paddr = 32'h7777_7AAA; rsp_lg = 5'd12;
    rsp_unc = 1'b1; rsp_lvl = 2'd3; out_ready = 1'b0; qry_vkey = 20'h12345;
    #2;
    chk(out_valid && !rsp_ready, "R8 hold while stalled", {30'd0, out_valid, rsp_ready}, 2);
    chk(out_paddr == 32'h7777_7010, "R7 first member", out_paddr, 32'h7777_7010);
    @(negedge clk);
    #2;
    chk(out_valid && out_paddr == 32'h7777_7010 && out_port == 2'd3, "R7 stall stable", out_paddr, 32'h7777_7010);
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #2;
      chk(out_paddr == exp_pa(m_va[i], 32'h7777_7AAA, 12), "R2 member paddr", out_paddr,
          exp_pa(m_va[i], 32'h7777_7AAA, 12));
      chk(out_port == m_pt[i], "R5 member port", 32'(out_port), 32'(m_pt[i]));
      chk(out_pop == !m_pf[i], "R6 member pop", 32'(out_pop), 32'(!m_pf[i]));
      chk(out_unc && out_lvl == 2'd3, "R3 R4 member attrs", {29'd0, out_unc, out_lvl}, 7);
      chk(out_last == (i == 2), "R7 last flag", 32'(out_last), 32'(i == 2));
      chk(rsp_ready == (i == 2), "R8 ready timing", 32'(rsp_ready), 32'(i == 2));
      chk(clr == (i == 2), "R9 clr timing", 32'(clr), 32'(i == 2));
      chk(qry_hit == 1'b1, "R9 still outstanding", 32'(qry_hit), 1);
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    #2;
    chk(qry_hit == 1'b0, "R9 retired entry gone", 32'(qry_hit), 0);
    qry_vkey = 20'h0ABCD;
    #1;
    chk(qry_hit == 1'b1, "R9 neighbour kept", 32'(qry_hit), 1);

    // R10 miss
    @(negedge clk);
    rsp_valid = 1'b1; rsp_vkey = 20'h55555;
    #2;
    chk(err && rsp_ready && !out_valid, "R10 miss flagged", {29'd0, err, rsp_ready, out_valid}, 6);
    @(negedge clk);
    rsp_valid = 1'b0;
    #2;
    chk(err == 1'b0, "R10 err clears", 32'(err), 0);
    chk(qry_hit == 1'b1, "R10 table untouched", 32'(qry_hit), 1);

    finish_run();
  end
endmodule